// File: doc/BRIEF.md
# Descriptor-Chained Receive DMA Channel

This block is one receive DMA channel. It takes bytes from a byte-stream input and stores them in memory buffers. The buffers are described by a linked list of four-word descriptors. Each descriptor holds a control word, a device status word, a buffer address and a link pointer. The channel fetches a descriptor, fills its buffer byte by byte and decrements the count field as it goes. It then writes back the control word with a completion flag, followed by the status word. After that it moves on through the link pointer or through a next-pointer register that software fills in. If neither applies, it halts.

Software drives the channel through a small register port with five registers: control, status, status mask, current descriptor pointer and next descriptor pointer. It starts the channel by writing a descriptor address. It queues more work by writing the next pointer, which reads back zero once the channel has consumed it. It stops the channel by setting a stop bit and then waiting for HALT. An interrupt line goes high while any unmasked status bit is set. Memory is a request/acknowledge port with an error flag.

The engine has six states:

- IDLE: the channel waits for work.
- FETCH: it reads the four descriptor words.
- XFER: it waits for a byte.
- WRITE: it stores one byte.
- WB_CTL: it writes back the control word.
- WB_STAT: it writes back the status word.

Transitions:

- start: IDLE to FETCH.
- fetched: FETCH to XFER.
- accept: XFER to WRITE.
- more: WRITE to XFER.
- frame end: WRITE to WB_CTL.
- exhausted: XFER to WB_CTL.
- ctl written: WB_CTL to WB_STAT.
- follow link, or take next pointer: WB_STAT to FETCH.
- halt: from IDLE, XFER, WB_STAT or any memory error, to IDLE, raising HALT.

Top module: `dcdma_channel`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `in_ready` is low.
- R2: Register addresses are control 0, status 1, mask 2, descriptor pointer 3 and next pointer 4. Writing a nonzero value to the descriptor pointer while idle starts the channel. It reads four words at pointer+0 (control), +4 (device status), +8 (buffer address) and +12 (link). A memory request is held with a stable address until it is acknowledged.
- R3: In the control word, bits 15:0 hold the remaining byte count. Each accepted byte is written to the current buffer address with a one-hot byte enable selected by address bits 1:0, and the address then advances. `in_ready` is high only while the count is nonzero.
- R4: A byte marked last ends the descriptor by frame end. Otherwise the descriptor ends by exhaustion when the count reaches zero. Completion first writes the control word back with the updated count and sets bit 20 (frame end) or bit 21 (exhausted). It then writes the device status word: bit 31 is the frame-end flag and bits 15:0 are the number of bytes stored.
- R5: When the ending cause has its chain flag set (bit 18 for frame end, bit 19 for exhaustion) and the link is nonzero, the channel continues at the link.
- R6: When the link is not followed and the next pointer is nonzero, the channel continues there, and the next pointer then reads 0. A nonzero next pointer written while idle starts the channel at that address. The next pointer reads back what was written until it is consumed.
- R7: When neither R5 nor R6 applies, the channel sets HALT and goes idle. Control bit 0 reads 1 only while the channel is busy.
- R8: Status bits are: bit 0 frame end (only if control bit 16 is set), bit 1 exhausted (only if control bit 17 is set), bit 2 HALT and bit 3 ERROR. A status write clears the bits written as 0 and keeps the bits written as 1. A bit the hardware sets on the same edge stays set.
- R9: `irq` is high exactly when some status bit is set and the mask bit at the same position is 0.
- R10: Writing control bit 4 (stop) while the channel waits for a byte sets HALT one clock edge after the write. The channel goes idle without writing back, and the stop bit then reads 0.
- R11: A memory error response sets ERROR and HALT and stops the channel with no further memory writes.
- R12: A write to the descriptor pointer while the channel is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| mem_err | input | 1 | Memory error, valid with acknowledge |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte ends the frame |
| in_ready | output | 1 | Channel accepts the byte |

## Verification
A software write to the status register and a hardware HALT can land on the same clock edge. The first clears status bits; the second sets one. The bench provokes this during an abort. It writes the stop bit while the channel is waiting for a byte, and writes all-zero status on the very next cycle. That second write meets the edge on which the channel raises HALT. The status read afterwards must show HALT alone: the earlier bits are cleared and the new one is kept.

// File: rtl/dcdma_pkg.sv
package dcdma_pkg;
    localparam int WORD_W    = 32;
    localparam int DESC_WDS  = 4;
    localparam int IDX_W     = $clog2(DESC_WDS);
    localparam int ST_W      = 4;
    // status bit positions
    localparam int ST_FEND   = 0;
    localparam int ST_EXH    = 1;
    localparam int ST_HALT   = 2;
    localparam int ST_ERR    = 3;
    // control word flag positions
    localparam int CF_IRQ_FEND = 16;
    localparam int CF_IRQ_EXH  = 17;
    localparam int CF_CH_FEND  = 18;
    localparam int CF_CH_EXH   = 19;
    localparam int CF_FEND     = 20;
    localparam int CF_EXH      = 21;
    localparam int DS_FEND     = 31;
    // register map
    localparam logic [2:0] RA_CTL  = 3'd0;
    localparam logic [2:0] RA_STAT = 3'd1;
    localparam logic [2:0] RA_MASK = 3'd2;
    localparam logic [2:0] RA_DPTR = 3'd3;
    localparam logic [2:0] RA_NDPTR = 3'd4;
    localparam int CTL_STOP = 4;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_XFER, S_WRITE, S_WB_CTL, S_WB_STAT
    } eng_state_e;
endpackage

// File: rtl/dcdma_status.sv
module dcdma_status
    import dcdma_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] set_i,
    input  logic            st_we,
    input  logic            mask_we,
    input  logic [ST_W-1:0] wdata_i,
    output logic [ST_W-1:0] status_o,
    output logic [ST_W-1:0] mask_o,
    output logic            irq_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_o <= '0;
            mask_o   <= '0;
        end else begin
            status_o <= (st_we ? (status_o & wdata_i) : status_o) | set_i;
            if (mask_we)
                mask_o <= wdata_i;
        end
    end

    assign irq_o = |(status_o & ~mask_o);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && set_i == '0) |=> ((status_o & ~$past(wdata_i)) == '0));
endmodule

// File: rtl/dcdma_engine.sv
module dcdma_engine
    import dcdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dptr_we,
    input  logic              ndptr_we,
    input  logic [AW-1:0]     wdata_i,
    input  logic              stop_i,
    output logic [AW-1:0]     dptr_o,
    output logic [AW-1:0]     ndptr_o,
    output logic              busy_o,
    output logic [ST_W-1:0]   set_o,
    output logic              halt_ack_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic [3:0]        mem_be_o,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_err_i,
    input  logic              in_valid_i,
    input  logic [7:0]        in_data_i,
    input  logic              in_last_i,
    output logic              in_ready_o
);
    eng_state_e        state_q;
    logic [WORD_W-1:0] ctl_q;
    logic [AW-1:0]     buf_q, link_q;
    logic [IDX_W-1:0]  idx_q;
    logic [7:0]        byte_q;
    logic              last_q, fend_q;
    logic [CW-1:0]     stored_q;

    logic acc, ok, bad, go_halt, take_nd, take_link, chain_en;

    assign acc      = mem_req_o & mem_ack_i;
    assign ok       = acc & ~mem_err_i;
    assign bad      = acc & mem_err_i;
    assign chain_en = fend_q ? ctl_q[CF_CH_FEND] : ctl_q[CF_CH_EXH];
    assign busy_o   = (state_q != S_IDLE);

    // continuation decision
    always_comb begin
        go_halt   = 1'b0;
        take_nd   = 1'b0;
        take_link = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (stop_i)                 go_halt = 1'b1;
                else if (ndptr_o != '0)     take_nd = 1'b1;
            end
            S_XFER: if (stop_i)             go_halt = 1'b1;
            S_WB_STAT: if (ok) begin
                if (stop_i)                 go_halt   = 1'b1;
                else if (chain_en && link_q != '0) take_link = 1'b1;
                else if (ndptr_o != '0)     take_nd   = 1'b1;
                else                        go_halt   = 1'b1;
            end
            default: ;
        endcase
        if (bad) go_halt = 1'b1;
    end

    always_comb begin
        set_o            = '0;
        set_o[ST_HALT]   = go_halt;
        set_o[ST_ERR]    = bad;
        set_o[ST_FEND]   = (state_q == S_WB_STAT) && ok && fend_q && ctl_q[CF_IRQ_FEND];
        set_o[ST_EXH]    = (state_q == S_WB_STAT) && ok && !fend_q && ctl_q[CF_IRQ_EXH];
    end
    assign halt_ack_o = go_halt & stop_i;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            dptr_o   <= '0;
            ndptr_o  <= '0;
            ctl_q    <= '0;
            buf_q    <= '0;
            link_q   <= '0;
            idx_q    <= '0;
            byte_q   <= '0;
            last_q   <= 1'b0;
            fend_q   <= 1'b0;
            stored_q <= '0;
        end else begin
            if (take_nd)  ndptr_o <= '0;
            if (ndptr_we) ndptr_o <= wdata_i;
            if (go_halt) begin
                state_q <= S_IDLE;
            end else begin
                unique case (state_q)
                    S_IDLE: begin
                        if (take_nd) begin
                            dptr_o  <= ndptr_o;
                            idx_q   <= '0;
                            state_q <= S_FETCH;
                        end else if (dptr_we) begin
                            dptr_o <= wdata_i;
                            idx_q  <= '0;
                            if (wdata_i != '0) state_q <= S_FETCH;
                        end
                    end
                    S_FETCH: if (ok) begin
                        unique case (idx_q)
                            IDX_W'(0): ctl_q  <= mem_rdata_i;
                            IDX_W'(2): buf_q  <= mem_rdata_i[AW-1:0];
                            IDX_W'(3): link_q <= mem_rdata_i[AW-1:0];
                            default: ;
                        endcase
                        idx_q <= idx_q + IDX_W'(1);
                        if (idx_q == IDX_W'(DESC_WDS - 1)) begin
                            stored_q <= '0;
                            last_q   <= 1'b0;
                            state_q  <= S_XFER;
                        end
                    end
                    S_XFER: begin
                        if (in_valid_i && in_ready_o) begin
                            byte_q  <= in_data_i;
                            last_q  <= in_last_i;
                            state_q <= S_WRITE;
                        end else if (ctl_q[CW-1:0] == '0) begin
                            fend_q  <= 1'b0;
                            state_q <= S_WB_CTL;
                        end
                    end
                    S_WRITE: if (ok) begin
                        buf_q          <= buf_q + AW'(1);
                        ctl_q[CW-1:0]  <= ctl_q[CW-1:0] - CW'(1);
                        stored_q       <= stored_q + CW'(1);
                        if (last_q) begin
                            fend_q  <= 1'b1;
                            state_q <= S_WB_CTL;
                        end else begin
                            state_q <= S_XFER;
                        end
                    end
                    S_WB_CTL: if (ok) state_q <= S_WB_STAT;
                    S_WB_STAT: begin
                        if (take_link || take_nd) begin
                            dptr_o  <= take_link ? link_q : ndptr_o;
                            idx_q   <= '0;
                            state_q <= S_FETCH;
                        end
                    end
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = dptr_o;
        mem_wdata_o = '0;
        mem_be_o    = 4'hF;
        in_ready_o  = 1'b0;
        unique case (state_q)
            S_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = dptr_o + AW'({idx_q, 2'b00});
            end
            S_XFER: in_ready_o = (ctl_q[CW-1:0] != '0) && !stop_i;
            S_WRITE: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = {buf_q[AW-1:2], 2'b00};
                mem_wdata_o = {4{byte_q}};
                mem_be_o    = 4'b0001 << buf_q[1:0];
            end
            S_WB_CTL: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = ctl_q;
                mem_wdata_o[CF_FEND] = ctl_q[CF_FEND] | fend_q;
                mem_wdata_o[CF_EXH]  = ctl_q[CF_EXH] | !fend_q;
            end
            S_WB_STAT: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = dptr_o + AW'(4);
                mem_wdata_o = WORD_W'(stored_q);
                mem_wdata_o[DS_FEND] = fend_q;
            end
            default: ;
        endcase
    end

    p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

    p_halt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_o[ST_HALT] |=> !busy_o);

    p_nd_consumed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_nd && !ndptr_we) |=> (ndptr_o == '0));
endmodule

// File: rtl/dcdma_channel.sv
module dcdma_channel
    import dcdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready
);
    logic            stop_q, busy, halt_ack;
    logic [AW-1:0]   dptr, ndptr;
    logic [ST_W-1:0] set_bits, status, mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stop_q <= 1'b0;
        else if (reg_we && reg_addr == RA_CTL)
            stop_q <= reg_wdata[CTL_STOP];
        else if (halt_ack)
            stop_q <= 1'b0;
    end

    dcdma_engine #(.AW(AW), .CW(CW)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .dptr_we     (reg_we && reg_addr == RA_DPTR),
        .ndptr_we    (reg_we && reg_addr == RA_NDPTR),
        .wdata_i     (reg_wdata[AW-1:0]),
        .stop_i      (stop_q),
        .dptr_o      (dptr),
        .ndptr_o     (ndptr),
        .busy_o      (busy),
        .set_o       (set_bits),
        .halt_ack_o  (halt_ack),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_be_o    (mem_be),
        .mem_ack_i   (mem_ack),
        .mem_rdata_i (mem_rdata),
        .mem_err_i   (mem_err),
        .in_valid_i  (in_valid),
        .in_data_i   (in_data),
        .in_last_i   (in_last),
        .in_ready_o  (in_ready)
    );

    dcdma_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_bits),
        .st_we    (reg_we && reg_addr == RA_STAT),
        .mask_we  (reg_we && reg_addr == RA_MASK),
        .wdata_i  (reg_wdata[ST_W-1:0]),
        .status_o (status),
        .mask_o   (mask),
        .irq_o    (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTL:   begin
                reg_rdata[CTL_STOP] = stop_q;
                reg_rdata[0]        = busy;
            end
            RA_STAT:  reg_rdata = 32'(status);
            RA_MASK:  reg_rdata = 32'(mask);
            RA_DPTR:  reg_rdata = 32'(dptr);
            RA_NDPTR: reg_rdata = 32'(ndptr);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: tb/test_dcdma_channel.sv
module test_dcdma_channel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;

    logic [31:0] mem [0:255];
    int          err_word = -1;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcdma_channel i_dcdma_channel (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready)
    );

    // memory responder: one access per two cycles
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_err   <= (int'(mem_addr[9:2]) == err_word);
            mem_rdata <= mem[mem_addr[9:2]];
            if (mem_we && int'(mem_addr[9:2]) != err_word)
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic put_desc(input int w, input logic [31:0] c, input logic [31:0] b, input logic [31:0] l);
        mem[w] = c; mem[w+1] = 32'h0; mem[w+2] = b; mem[w+3] = l;
        mem[b[9:2]] = 32'h0;
    endtask

    task automatic send(input logic [7:0] d, input logic last);
        int t;
        in_valid = 1'b1; in_data = d; in_last = last;
        t = 0;
        while (!in_ready && t < 200) begin @(negedge clk); t++; end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 500; i++) begin
            rd(3'd0, v);
            if (v[0] == 1'b0) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 register reset", v, 32'h0);
        end
        chk("R1 irq reset", 32'(irq), 32'h0);
        chk("R1 in_ready reset", 32'(in_ready), 32'h0);
    endtask

    task automatic t_frame_end();
        logic [31:0] v;
        put_desc(16, 32'h0001_0008, 32'h200, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd3, 32'h40);
        send(8'hA1, 0); send(8'hA2, 0); send(8'hA3, 1);
        wait_idle();
        chk("R3 bytes stored", mem[128], 32'h00A3_A2A1);
        chk("R4 control writeback frame end", mem[16], 32'h0011_0005);
        chk("R4 device status word", mem[17], 32'h8000_0003);
        rd(3'd1, v);
        chk("R8 R7 status frame end + halt", v, 32'h5);
        chk("R9 irq unmasked", 32'(irq), 32'h1);
    endtask

    task automatic t_exhaust();
        logic [31:0] v;
        put_desc(16, 32'h0002_0002, 32'h210, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd3, 32'h40);
        send(8'hB1, 0); send(8'hB2, 0);
        wait_idle();
        chk("R3 exhausted buffer", mem[132], 32'h0000_B2B1);
        chk("R4 control writeback exhausted", mem[16], 32'h0022_0000);
        chk("R4 status word exhausted", mem[17], 32'h0000_0002);
        rd(3'd1, v);
        chk("R8 status exhausted + halt", v, 32'h6);
        chk("R3 in_ready low after exhaustion", 32'(in_ready), 32'h0);
    endtask

    task automatic t_link();
        logic [31:0] v;
        put_desc(16, 32'h0008_0002, 32'h220, 32'h60);
        put_desc(24, 32'h0001_0004, 32'h230, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd3, 32'h40);
        send(8'hC1, 0); send(8'hC2, 0); send(8'hC3, 0); send(8'hC4, 1);
        wait_idle();
        chk("R5 first buffer", mem[136], 32'h0000_C2C1);
        chk("R5 second buffer", mem[140], 32'h0000_C4C3);
        chk("R5 first control", mem[16], 32'h0028_0000);
        chk("R5 second control", mem[24], 32'h0011_0002);
        rd(3'd1, v);
        chk("R8 status after link", v, 32'h5);
        rd(3'd3, v);
        chk("R5 dptr at linked descriptor", v, 32'h60);
    endtask

    task automatic t_next_ptr();
        logic [31:0] v;
        put_desc(16, 32'h0000_0001, 32'h240, 32'h0);
        put_desc(24, 32'h0002_0001, 32'h250, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd3, 32'h40);
        wr(3'd4, 32'h60);
        rd(3'd4, v);
        chk("R6 next pointer readback", v, 32'h60);
        send(8'hD1, 0);
        send(8'hD2, 0);
        wait_idle();
        rd(3'd4, v);
        chk("R6 next pointer consumed", v, 32'h0);
        rd(3'd3, v);
        chk("R6 dptr moved", v, 32'h60);
        chk("R6 second buffer", mem[148], 32'h0000_00D2);
        rd(3'd1, v);
        chk("R8 status after next pointer", v, 32'h6);
        // idle start through next pointer
        put_desc(16, 32'h0001_0001, 32'h260, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd4, 32'h40);
        send(8'hE1, 1);
        wait_idle();
        chk("R6 idle start buffer", mem[152], 32'h0000_00E1);
        rd(3'd1, v);
        chk("R6 idle start status", v, 32'h5);
    endtask

    task automatic t_status_mask();
        logic [31:0] v;
        wr(3'd1, 32'hFFFF_FFFB);
        rd(3'd1, v);
        chk("R8 partial clear", v, 32'h1);
        wr(3'd2, 32'h1);
        chk("R9 masked irq", 32'(irq), 32'h0);
        wr(3'd2, 32'h0);
        chk("R9 unmasked irq", 32'(irq), 32'h1);
        wr(3'd1, 32'h0);
        chk("R9 irq after clear", 32'(irq), 32'h0);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        int t;
        put_desc(16, 32'h0000_0004, 32'h270, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd3, 32'h40);
        t = 0;
        while (!in_ready && t < 200) begin @(negedge clk); t++; end
        wr(3'd3, 32'h60);
        rd(3'd3, v);
        chk("R12 dptr write while busy ignored", v, 32'h40);
        wr(3'd1, 32'h1);          // keep bit0 only (nothing set yet)
        wr(3'd0, 32'h10);         // stop
        wr(3'd1, 32'h0);          // clear lands on the halt edge
        rd(3'd1, v);
        chk("R10 R8 halt wins over same-edge clear", v, 32'h4);
        rd(3'd0, v);
        chk("R10 stop self-clears and idle", v, 32'h0);
        chk("R10 control not written back", mem[16], 32'h0000_0004);
    endtask

    task automatic t_mem_err();
        logic [31:0] v;
        put_desc(16, 32'h0001_0004, 32'h280, 32'h0);
        wr(3'd1, 32'h0);
        err_word = 19;
        wr(3'd3, 32'h40);
        wait_idle();
        err_word = -1;
        rd(3'd1, v);
        chk("R11 error and halt", v, 32'hC);
        chk("R11 no writeback", mem[16], 32'h0001_0004);
        rd(3'd0, v);
        chk("R11 channel idle", v, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_frame_end();
        t_exhaust();
        t_link();
        t_next_ptr();
        t_status_mask();
        t_abort();
        t_mem_err();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule